// File: doc/BRIEF.md
# Feedback-Queue Operand Forwarding Datapath

This block is the execute stage of a scalar machine that issues two ALU operations together in each instruction word. It avoids wide register-file porting. Each ALU keeps a short shift queue of the results it produced in the last few cycles. Any operand of either ALU can read any entry of either queue. Most values therefore travel from producer to consumer without touching the register file. The register file is small, with two read ports and one write port.

Every cycle, each ALU pushes its result into its own queue, and every older entry moves one place deeper. The select code of an operand therefore names the age of a value in cycles. A value is reachable only while it is in the queue. To keep it longer, either re-issue it with a move operation or copy it into a register through the write port. The write port chooses its data with the same select codes as the operands.

Top module: `fbq_exec_datapath`

## Requirements
- R1: While `rst_n` is low, all queue entries and all registers are cleared to zero, and `res0_o`/`res1_o` read zero.
- R2: On every clock edge, each lane pushes its ALU result into its own queue, whatever the operation. `res0_o` and `res1_o` show the lane results of the instruction presented one cycle earlier.
- R3: Select codes 0 to 3 return the lane-0 result produced exactly code+1 cycles before the current cycle.
- R4: Select codes 4 to 7 return the lane-1 result produced exactly code-3 cycles before the current cycle.
- R5: Select code 8 returns the register addressed by `rd_addr_a`, and code 9 returns the register addressed by `rd_addr_b`.
- R6: When `wr_en` is high at a clock edge, register `wr_addr` takes the value picked by `wr_sel`, using the operand codes, with code 10 meaning `wr_imm`. A read in the same cycle still returns the old value. Reads from the next cycle on return the new value.
- R7: Select code 10 returns the issuing lane's own immediate.
- R8: Select codes 11 to 15 return zero.
- R9: Operation codes are 0 = a+b, 1 = low 32 bits of a*b, 2 = a (move), 3 = a-b, all modulo 2^32.
- R10: Both lanes execute in the same cycle, independently of each other. Each lane may read the other lane's queue and the register ports at the same time as the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l0_op | input | 2 | Lane 0 operation code |
| l0_sel_a | input | 4 | Lane 0 first operand select |
| l0_sel_b | input | 4 | Lane 0 second operand select |
| l0_imm | input | 32 | Lane 0 immediate |
| l1_op | input | 2 | Lane 1 operation code |
| l1_sel_a | input | 4 | Lane 1 first operand select |
| l1_sel_b | input | 4 | Lane 1 second operand select |
| l1_imm | input | 32 | Lane 1 immediate |
| rd_addr_a | input | 4 | Register read port A address |
| rd_addr_b | input | 4 | Register read port B address |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_sel | input | 4 | Write data select (operand codes) |
| wr_imm | input | 32 | Immediate for write select code 10 |
| res0_o | output | 32 | Lane 0 result of the previous instruction |
| res1_o | output | 32 | Lane 1 result of the previous instruction |

## Verification
The hardest case to reach is a read from the deepest queue slot. It must return the value from exactly four cycles back, and that value must not have been disturbed by the unrelated results pushed in between. The stimulus fills both queues with distinct marked values over four cycles and then reads the oldest slots across lanes. It then runs a long pseudo-random instruction stream, with every select code, operation and register write enabled, against a cycle-accurate history model kept in the bench. A further sequence writes a register and reads it in the same cycle, to expose the old-versus-new value ordering.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_MOV = 2'd2,
    OP_SUB = 2'd3
  } fbq_op_e;

  // scalar ALU arithmetic, results wrap modulo 2^DW
  function automatic logic [DW-1:0] fbq_alu(fbq_op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_MUL:  r = a * b;
      OP_MOV:  r = a;
      default: r = a - b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fbq_result_queue.sv
module fbq_result_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] entry [DEPTH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry[0] <= '0;
    else        entry[0] <= push_data;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry[i] <= '0;
      else        entry[i] <= entry[i-1];
    end

    // R3
    queue_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> entry[i] == $past(entry[i-1]));
  end
endmodule

// File: rtl/fbq_regfile.sv
module fbq_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];

  // R6
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/fbq_operand_mux.sv
module fbq_operand_mux #(
  parameter int DW     = 32,
  parameter int QDEPTH = 4,
  localparam int SELW  = $clog2(2*QDEPTH+3)
) (
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   q0 [QDEPTH],
  input  logic [DW-1:0]   q1 [QDEPTH],
  input  logic [DW-1:0]   rd_a,
  input  logic [DW-1:0]   rd_b,
  input  logic [DW-1:0]   imm,
  output logic [DW-1:0]   value
);
  localparam int CODE_RA  = 2*QDEPTH;
  localparam int CODE_RB  = 2*QDEPTH + 1;
  localparam int CODE_IMM = 2*QDEPTH + 2;

  always_comb begin
    value = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (sel == SELW'(i))          value = q0[i];
      if (sel == SELW'(QDEPTH + i)) value = q1[i];
    end
    if (sel == SELW'(CODE_RA))  value = rd_a;
    if (sel == SELW'(CODE_RB))  value = rd_b;
    if (sel == SELW'(CODE_IMM)) value = imm;
  end
endmodule

// File: rtl/fbq_exec_datapath.sv
module fbq_exec_datapath
  import fbq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int NREG   = 16,
  localparam int SELW  = $clog2(2*QDEPTH+3),
  localparam int AW    = $clog2(NREG),
  localparam int NLANE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      l0_op,
  input  logic [SELW-1:0] l0_sel_a,
  input  logic [SELW-1:0] l0_sel_b,
  input  logic [DW-1:0]   l0_imm,
  input  logic [1:0]      l1_op,
  input  logic [SELW-1:0] l1_sel_a,
  input  logic [SELW-1:0] l1_sel_b,
  input  logic [DW-1:0]   l1_imm,
  input  logic [AW-1:0]   rd_addr_a,
  input  logic [AW-1:0]   rd_addr_b,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_imm,
  output logic [DW-1:0]   res0_o,
  output logic [DW-1:0]   res1_o
);
  localparam int LAST_CODE = 2*QDEPTH + 2;

  logic [DW-1:0]   q0 [QDEPTH];
  logic [DW-1:0]   q1 [QDEPTH];
  logic [DW-1:0]   rdat_a, rdat_b, wdat;
  logic [1:0]      lane_op  [NLANE];
  logic [SELW-1:0] lane_sa  [NLANE];
  logic [SELW-1:0] lane_sb  [NLANE];
  logic [DW-1:0]   lane_imm [NLANE];
  logic [DW-1:0]   opnd_a   [NLANE];
  logic [DW-1:0]   opnd_b   [NLANE];
  logic [DW-1:0]   alu_res  [NLANE];

  assign lane_op[0]  = l0_op;    assign lane_op[1]  = l1_op;
  assign lane_sa[0]  = l0_sel_a; assign lane_sa[1]  = l1_sel_a;
  assign lane_sb[0]  = l0_sel_b; assign lane_sb[1]  = l1_sel_b;
  assign lane_imm[0] = l0_imm;   assign lane_imm[1] = l1_imm;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    fbq_operand_mux #(.DW(DW), .QDEPTH(QDEPTH)) u_mux_a (
      .sel(lane_sa[l]), .q0(q0), .q1(q1), .rd_a(rdat_a), .rd_b(rdat_b),
      .imm(lane_imm[l]), .value(opnd_a[l]));
    fbq_operand_mux #(.DW(DW), .QDEPTH(QDEPTH)) u_mux_b (
      .sel(lane_sb[l]), .q0(q0), .q1(q1), .rd_a(rdat_a), .rd_b(rdat_b),
      .imm(lane_imm[l]), .value(opnd_b[l]));

    assign alu_res[l] = fbq_alu(fbq_op_e'(lane_op[l]), opnd_a[l], opnd_b[l]);

    // R8
    invalid_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lane_sa[l]) > LAST_CODE) |-> opnd_a[l] == '0);
  end

  fbq_result_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue0 (
    .clk(clk), .rst_n(rst_n), .push_data(alu_res[0]), .entry(q0));
  fbq_result_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue1 (
    .clk(clk), .rst_n(rst_n), .push_data(alu_res[1]), .entry(q1));

  fbq_operand_mux #(.DW(DW), .QDEPTH(QDEPTH)) u_mux_wr (
    .sel(wr_sel), .q0(q0), .q1(q1), .rd_a(rdat_a), .rd_b(rdat_b),
    .imm(wr_imm), .value(wdat));

  fbq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rdat_a), .rd_data_b(rdat_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wdat));

  assign res0_o = q0[0];
  assign res1_o = q1[0];

  // R2
  result_push0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res0_o == $past(alu_res[0]));
  // R2
  result_push1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res1_o == $past(alu_res[1]));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (res0_o == '0 && res1_o == '0));
endmodule

// File: tb/fbq_exec_datapath_test.sv
module fbq_exec_datapath_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  l0_op = 2'd2, l1_op = 2'd2;
  logic [3:0]  l0_sel_a = 4'd11, l0_sel_b = 4'd11, l1_sel_a = 4'd11, l1_sel_b = 4'd11;
  logic [31:0] l0_imm = '0, l1_imm = '0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0, wr_sel = 4'd11;
  logic        wr_en = 1'b0;
  logic [31:0] wr_imm = '0;
  logic [31:0] res0_o, res1_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fbq_exec_datapath uut (
    .clk(clk), .rst_n(rst_n),
    .l0_op(l0_op), .l0_sel_a(l0_sel_a), .l0_sel_b(l0_sel_b), .l0_imm(l0_imm),
    .l1_op(l1_op), .l1_sel_a(l1_sel_a), .l1_sel_b(l1_sel_b), .l1_imm(l1_imm),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel), .wr_imm(wr_imm),
    .res0_o(res0_o), .res1_o(res1_o));

  // bench history model: h0[k-1] / h1[k-1] = result k cycles ago
  logic [31:0] h0 [4];
  logic [31:0] h1 [4];
  logic [31:0] regs [16];

  logic [31:0] exp0_q [$];
  logic [31:0] exp1_q [$];
  string       tag_q  [$];

  function automatic logic [31:0] pick(logic [3:0] s, logic [31:0] imm,
                                       logic [3:0] ra, logic [3:0] rb);
    if (s < 4)       return h0[s];
    else if (s < 8)  return h1[s - 4];
    else if (s == 8) return regs[ra];
    else if (s == 9) return regs[rb];
    else if (s == 10) return imm;
    return 32'd0;
  endfunction

  function automatic logic [31:0] ref_alu(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    case (op)
      2'd0: return a + b;
      2'd1: begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
      2'd2: return a;
      default: return a + (~b) + 32'd1;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: present one instruction word, push the expected results
  task automatic issue(logic [1:0] o0, logic [3:0] a0, logic [3:0] b0, logic [31:0] i0,
                       logic [1:0] o1, logic [3:0] a1, logic [3:0] b1, logic [31:0] i1,
                       logic [3:0] ra, logic [3:0] rb,
                       logic we, logic [3:0] wa, logic [3:0] ws, logic [31:0] wi,
                       string tag);
    logic [31:0] e0, e1, wv;
    @(negedge clk);
    l0_op = o0; l0_sel_a = a0; l0_sel_b = b0; l0_imm = i0;
    l1_op = o1; l1_sel_a = a1; l1_sel_b = b1; l1_imm = i1;
    rd_addr_a = ra; rd_addr_b = rb;
    wr_en = we; wr_addr = wa; wr_sel = ws; wr_imm = wi;
    e0 = ref_alu(o0, pick(a0, i0, ra, rb), pick(b0, i0, ra, rb));
    e1 = ref_alu(o1, pick(a1, i1, ra, rb), pick(b1, i1, ra, rb));
    wv = pick(ws, wi, ra, rb);
    exp0_q.push_back(e0);
    exp1_q.push_back(e1);
    tag_q.push_back(tag);
    for (int k = 3; k > 0; k--) begin h0[k] = h0[k-1]; h1[k] = h1[k-1]; end
    h0[0] = e0;
    h1[0] = e1;
    if (we) regs[wa] = wv;
  endtask

  // monitor: compare one scoreboard item after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp0_q.size() > 0) begin
        logic [31:0] e0, e1;
        string t;
        e0 = exp0_q.pop_front();
        e1 = exp1_q.pop_front();
        t  = tag_q.pop_front();
        check(t, "res0_o", res0_o, e0);
        check(t, "res1_o", res1_o, e1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin h0[k] = '0; h1[k] = '0; end
    for (int k = 0; k < 16; k++) regs[k] = '0;

    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared in reset
    check("R1", "res0_o in reset", res0_o, 32'd0);
    check("R1", "res1_o in reset", res1_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: oldest queue slot and registers read zero after reset
    issue(2, 3, 0, 0, 2, 8, 0, 0, 7, 0, 0, 0, 11, 0, "R1");
    issue(2, 7, 0, 0, 2, 9, 0, 0, 0, 15, 0, 0, 11, 0, "R1");

    // R7 and R6: load every register from the write immediate, lanes move immediates
    for (int r = 0; r < 16; r++)
      issue(2, 10, 0, 32'h500 + r, 2, 10, 0, 32'h900 + r, 0, 0,
            1, 4'(r), 10, 32'h1000 + 32'(r) * 3, "R7");

    // R5: register read ports
    issue(2, 8, 0, 0, 2, 9, 0, 0, 3, 12, 0, 0, 11, 0, "R5");
    issue(2, 9, 0, 0, 2, 8, 0, 0, 14, 1, 0, 0, 11, 0, "R5");

    // R9: each operation
    issue(0, 8, 9, 0, 1, 8, 10, 7, 2, 5, 0, 0, 11, 0, "R9");
    issue(3, 8, 9, 0, 3, 10, 8, 5, 1, 9, 0, 0, 11, 0, "R9");
    issue(1, 10, 10, 32'h10001, 0, 10, 10, 32'hFFFF_FFFF, 0, 0, 0, 0, 11, 0, "R9");
    issue(3, 10, 9, 32'd1, 1, 9, 10, 32'hDEAD_BEEF, 0, 6, 0, 0, 11, 0, "R9");

    // R3/R4: fill queues with marked values, then read the oldest slots
    for (int c = 0; c < 4; c++)
      issue(2, 10, 0, 32'd100 + c, 2, 10, 0, 32'd200 + c, 0, 0, 0, 0, 11, 0, "R2");
    issue(2, 3, 0, 0, 2, 7, 0, 0, 0, 0, 0, 0, 11, 0, "R3");
    issue(2, 2, 0, 0, 2, 6, 0, 0, 0, 0, 0, 0, 11, 0, "R4");
    issue(0, 0, 1, 0, 0, 4, 5, 0, 0, 0, 0, 0, 11, 0, "R3");
    // R10: each lane reads the other lane's queue in the same cycle
    issue(2, 4, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 11, 0, "R10");
    issue(0, 7, 3, 0, 3, 3, 7, 0, 0, 0, 0, 0, 11, 0, "R4");

    // R6: same-cycle read sees old value, next cycle sees new one
    issue(2, 8, 0, 0, 2, 8, 0, 0, 5, 0, 1, 5, 10, 32'd77, "R6");
    issue(2, 8, 0, 0, 2, 9, 0, 0, 5, 5, 0, 0, 11, 0, "R6");
    // R6: write from a queue entry (lane 0, age 1)
    issue(2, 10, 0, 32'hCAFE, 2, 10, 0, 0, 0, 0, 0, 0, 11, 0, "R6");
    issue(2, 11, 0, 0, 2, 11, 0, 0, 0, 0, 1, 6, 0, 0, "R6");
    issue(2, 8, 0, 0, 2, 9, 0, 0, 6, 6, 0, 0, 11, 0, "R6");

    // R8: reserved select codes
    issue(0, 11, 15, 32'h1234, 2, 12, 0, 32'h55, 0, 0, 0, 0, 11, 0, "R8");
    issue(0, 13, 14, 32'h1, 0, 14, 13, 32'h2, 0, 0, 1, 9, 15, 0, "R8");
    issue(2, 8, 0, 0, 2, 11, 0, 0, 9, 0, 0, 0, 11, 0, "R8");

    // R10: long pseudo-random stream against the history model
    for (int n = 0; n < 600; n++)
      issue(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), $urandom,
            2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), $urandom,
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
            1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), $urandom,
            "R10");

    @(negedge clk);
    l0_sel_a = 4'd11; l1_sel_a = 4'd11; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule